// File: doc/BRIEF.md
# Tournament branch direction predictor

This block predicts whether a conditional branch will be taken. It holds two component predictors. One is indexed by a shift register of recent branch outcomes across all branches. The other is a two-level scheme: a per-address history of that branch's own outcomes selects a counter. A table of per-address selector counters decides which component supplies the final answer.

A fetch stage presents a branch address on the lookup port. One cycle later it receives the final direction and both component directions. When the branch resolves, the pipeline returns the address, the real outcome and the two component directions it was given. The predictor then trains its counters and both histories.

No entry carries an address tag, so branches that share index bits share state. The design expects updates in program order. It expects no other update between the lookup and the update of the same branch.

Top module: `tourney_predictor`

## Requirements
- R1: After reset every two-bit counter holds 01 and every three-bit counter holds 011, both weakly not-taken. The global history and every local history hold zero, so a lookup at any address returns 0 on all three prediction outputs.
- R2: A lookup with `lk_en` high at a clock edge drives `pred_valid` high for the next cycle only, with the predictions for that address. `pred_valid` is low in the cycle after an edge with `lk_en` low.
- R3: The selector counter is taken from the low `CH_AW` bits of the address. A value of 2 or 3 picks the global component and 0 or 1 picks the local one. `pred_taken` equals the picked component's direction.
- R4: The global component reads the two-bit counter addressed by the current global history, and the counter's upper bit is its direction. On update, the counter addressed by the history before the shift steps by one toward the outcome, saturating at 0 and 3. From a strong state, the predicted direction flips only after two updates against it.
- R5: On each update the global history shifts left by one, with the outcome entering bit 0. Without an update it holds.
- R6: The local component reads the history at the low `LHT_AW` address bits. That history addresses a three-bit counter whose upper bit is the direction. On update, that counter steps toward the outcome, saturating at 0 and 7.
- R7: On update, the local history entry of the address shifts left with the outcome at bit 0. The counter trained is the one addressed by the history value before the shift.
- R8: On update, the selector steps up by one when the recorded global direction matched the outcome and the recorded local one did not. It steps down in the opposite case and holds when both recorded directions are equal. It saturates at 0 and 3.
- R9: Entries carry no tag. Two addresses equal in their low index bits read and train the same local history, local counter and selector.
- R10: When a lookup and an update fall on the same edge, the update is applied, but the lookup result reflects the table contents before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_en | input | 1 | Lookup request |
| lk_pc | input | PC_W | Branch address for lookup |
| upd_en | input | 1 | Update request |
| upd_pc | input | PC_W | Branch address being trained |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_glob_pred | input | 1 | Global direction given at lookup |
| upd_loc_pred | input | 1 | Local direction given at lookup |
| pred_valid | output | 1 | Prediction outputs belong to last cycle's lookup |
| pred_taken | output | 1 | Final direction |
| pred_glob | output | 1 | Global component direction |
| pred_loc | output | 1 | Local component direction |

## Verification
A lookup and an update can land on the same edge, including at the same address. Every table then has a read and a read-modify-write to the same entry. The bench provokes this by asserting both ports together at one address after that address's counters and histories have been trained. It requires the returned directions to match a model sampled before the update. A following lookup must show the trained state.

// File: rtl/tourney_pkg.sv
package tourney_pkg;

  typedef enum logic [1:0] {
    MOVE_HOLD = 2'd0,
    MOVE_UP   = 2'd1,
    MOVE_DOWN = 2'd2
  } move_t;

  // Step toward the resolved outcome.
  function automatic move_t toward(input logic taken);
    return taken ? MOVE_UP : MOVE_DOWN;
  endfunction

  // Selector training: favour the component that alone was right.
  function automatic move_t chooser_move(input logic taken,
                                         input logic glob,
                                         input logic loc);
    if (glob == loc) return MOVE_HOLD;
    return (glob == taken) ? MOVE_UP : MOVE_DOWN;
  endfunction

endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
  import tourney_pkg::*;
#(
  parameter int AW = 12,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_val,
  input  logic          up_en,
  input  logic [AW-1:0] up_addr,
  input  move_t         up_move
);
  localparam int            DEPTH = 1 << AW;
  localparam logic [CW-1:0] INIT  = {1'b0, {(CW-1){1'b1}}};
  localparam logic [CW-1:0] TOP   = '1;

  logic [CW-1:0] mem [DEPTH];
  logic [CW-1:0] cur;

  assign cur    = mem[up_addr];
  assign rd_val = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
    end else if (up_en) begin
      unique case (up_move)
        MOVE_UP:   if (cur != TOP) mem[up_addr] <= cur + 1'b1;
        MOVE_DOWN: if (cur != '0)  mem[up_addr] <= cur - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
  parameter int AW = 10,
  parameter int HW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr,
  output logic [HW-1:0] rd_hist,
  input  logic          up_en,
  input  logic [AW-1:0] up_addr,
  input  logic          up_taken,
  output logic [HW-1:0] up_hist_old
);
  localparam int DEPTH = 1 << AW;

  logic [HW-1:0] mem [DEPTH];

  assign rd_hist     = mem[rd_addr];
  assign up_hist_old = mem[up_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (up_en) begin
      mem[up_addr] <= {up_hist_old[HW-2:0], up_taken};
    end
  end
endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor
  import tourney_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int CH_AW  = 12,
  parameter int GH_W   = 12,
  parameter int LHT_AW = 10,
  parameter int LH_W   = 10,
  parameter int LC_W   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lk_en,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            upd_en,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_glob_pred,
  input  logic            upd_loc_pred,
  output logic            pred_valid,
  output logic            pred_taken,
  output logic            pred_glob,
  output logic            pred_loc
);
  localparam int GC_W = 2;
  localparam int SC_W = 2;

  logic [GH_W-1:0] ghist;

  logic [SC_W-1:0] lk_sel;
  logic [GC_W-1:0] lk_gctr;
  logic [LH_W-1:0] lk_lhist;
  logic [LC_W-1:0] lk_lctr;
  logic [LH_W-1:0] up_lhist;

  // Only the low address bits index the tables; upper bits are dropped.
  logic unused_pc_bits;
  assign unused_pc_bits = ^{lk_pc, upd_pc};

  always_ff @(posedge clk) begin
    if (rst)         ghist <= '0;
    else if (upd_en) ghist <= {ghist[GH_W-2:0], upd_taken};
  end

  tp_ctr_table #(.AW(CH_AW), .CW(SC_W)) u_sel (
    .clk(clk), .rst(rst),
    .rd_addr(lk_pc[CH_AW-1:0]), .rd_val(lk_sel),
    .up_en(upd_en), .up_addr(upd_pc[CH_AW-1:0]),
    .up_move(chooser_move(upd_taken, upd_glob_pred, upd_loc_pred))
  );

  tp_ctr_table #(.AW(GH_W), .CW(GC_W)) u_glob (
    .clk(clk), .rst(rst),
    .rd_addr(ghist), .rd_val(lk_gctr),
    .up_en(upd_en), .up_addr(ghist),
    .up_move(toward(upd_taken))
  );

  tp_hist_table #(.AW(LHT_AW), .HW(LH_W)) u_lhist (
    .clk(clk), .rst(rst),
    .rd_addr(lk_pc[LHT_AW-1:0]), .rd_hist(lk_lhist),
    .up_en(upd_en), .up_addr(upd_pc[LHT_AW-1:0]),
    .up_taken(upd_taken), .up_hist_old(up_lhist)
  );

  tp_ctr_table #(.AW(LH_W), .CW(LC_W)) u_loc (
    .clk(clk), .rst(rst),
    .rd_addr(lk_lhist), .rd_val(lk_lctr),
    .up_en(upd_en), .up_addr(up_lhist),
    .up_move(toward(upd_taken))
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      pred_taken <= 1'b0;
      pred_glob  <= 1'b0;
      pred_loc   <= 1'b0;
    end else begin
      pred_valid <= lk_en;
      if (lk_en) begin
        pred_glob  <= lk_gctr[GC_W-1];
        pred_loc   <= lk_lctr[LC_W-1];
        pred_taken <= lk_sel[SC_W-1] ? lk_gctr[GC_W-1] : lk_lctr[LC_W-1];
      end
    end
  end
endmodule

// File: rtl/tourney_checker.sv
module tourney_checker #(
  parameter int GH_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            lk_en,
  input logic            upd_en,
  input logic            upd_taken,
  input logic            pred_valid,
  input logic            pred_taken,
  input logic            pred_glob,
  input logic            pred_loc,
  input logic [GH_W-1:0] ghist
);
  assert_valid_after_lookup_R2: assert property (@(posedge clk) disable iff (rst)
    lk_en |=> pred_valid);

  assert_valid_low_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !lk_en |=> !pred_valid);

  assert_agree_passes_R3: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && (pred_glob == pred_loc)) |-> (pred_taken == pred_glob));

  assert_ghist_shift_in_R5: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> (ghist[0] == $past(upd_taken)) &&
               (ghist[GH_W-1:1] == $past(ghist[GH_W-2:0])));

  assert_ghist_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> (ghist == $past(ghist)));
endmodule

bind tourney_predictor tourney_checker #(.GH_W(GH_W)) u_chk (
  .clk(clk), .rst(rst), .lk_en(lk_en), .upd_en(upd_en),
  .upd_taken(upd_taken), .pred_valid(pred_valid), .pred_taken(pred_taken),
  .pred_glob(pred_glob), .pred_loc(pred_loc), .ghist(ghist)
);

// File: tb/tb_tourney_predictor.sv
`timescale 1ns/1ps
module tb_tourney_predictor;
  localparam int PC_W   = 16;
  localparam int CH_AW  = 4;
  localparam int GH_W   = 4;
  localparam int LHT_AW = 3;
  localparam int LH_W   = 3;
  localparam int LC_W   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_en = 1'b0, upd_en = 1'b0;
  logic [PC_W-1:0] lk_pc = '0, upd_pc = '0;
  logic upd_taken = 1'b0, upd_glob_pred = 1'b0, upd_loc_pred = 1'b0;
  logic pred_valid, pred_taken, pred_glob, pred_loc;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  tourney_predictor #(.PC_W(PC_W), .CH_AW(CH_AW), .GH_W(GH_W),
                      .LHT_AW(LHT_AW), .LH_W(LH_W), .LC_W(LC_W)) dut (
    .clk(clk), .rst(rst), .lk_en(lk_en), .lk_pc(lk_pc),
    .upd_en(upd_en), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_glob_pred(upd_glob_pred), .upd_loc_pred(upd_loc_pred),
    .pred_valid(pred_valid), .pred_taken(pred_taken),
    .pred_glob(pred_glob), .pred_loc(pred_loc)
  );

  // Reference state built from the requirements.
  logic [1:0]      m_ch  [1<<CH_AW];
  logic [1:0]      m_gc  [1<<GH_W];
  logic [LH_W-1:0] m_lht [1<<LHT_AW];
  logic [LC_W-1:0] m_lc  [1<<LH_W];
  logic [GH_W-1:0] m_gh;

  // {taken, pc}
  localparam logic [16:0] VEC [24] = '{
    17'h1_0010, 17'h1_0010, 17'h0_0023, 17'h1_0010, 17'h0_0023, 17'h1_0037,
    17'h1_0037, 17'h0_0010, 17'h1_0023, 17'h1_0023, 17'h1_0023, 17'h0_0037,
    17'h1_0010, 17'h1_0010, 17'h0_004C, 17'h0_004C, 17'h1_0037, 17'h0_0023,
    17'h1_004C, 17'h1_0010, 17'h0_0010, 17'h1_0037, 17'h0_004C, 17'h1_0023
  };

  task automatic model_reset();
    for (int i = 0; i < (1<<CH_AW); i++)  m_ch[i]  = 2'b01;
    for (int i = 0; i < (1<<GH_W); i++)   m_gc[i]  = 2'b01;
    for (int i = 0; i < (1<<LHT_AW); i++) m_lht[i] = '0;
    for (int i = 0; i < (1<<LH_W); i++)   m_lc[i]  = 3'b011;
    m_gh = '0;
  endtask

  task automatic model_predict(input logic [PC_W-1:0] pc,
                               output logic g, output logic l, output logic f);
    g = m_gc[m_gh][1];
    l = m_lc[m_lht[pc[LHT_AW-1:0]]][LC_W-1];
    f = m_ch[pc[CH_AW-1:0]][1] ? g : l;
  endtask

  task automatic model_update(input logic [PC_W-1:0] pc, input logic t,
                              input logic g, input logic l);
    logic [LH_W-1:0] h;
    if (g == t && l != t && m_ch[pc[CH_AW-1:0]] != 2'd3)
      m_ch[pc[CH_AW-1:0]] = m_ch[pc[CH_AW-1:0]] + 2'd1;
    else if (l == t && g != t && m_ch[pc[CH_AW-1:0]] != 2'd0)
      m_ch[pc[CH_AW-1:0]] = m_ch[pc[CH_AW-1:0]] - 2'd1;
    if (t && m_gc[m_gh] != 2'd3)       m_gc[m_gh] = m_gc[m_gh] + 2'd1;
    else if (!t && m_gc[m_gh] != 2'd0) m_gc[m_gh] = m_gc[m_gh] - 2'd1;
    h = m_lht[pc[LHT_AW-1:0]];
    if (t && m_lc[h] != 3'd7)       m_lc[h] = m_lc[h] + 3'd1;
    else if (!t && m_lc[h] != 3'd0) m_lc[h] = m_lc[h] - 3'd1;
    m_lht[pc[LHT_AW-1:0]] = {h[LH_W-2:0], t};
    m_gh = {m_gh[GH_W-2:0], t};
  endtask

  task automatic chk(input logic act, input logic exp, input string tag,
                     input string what);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; lk_en = 1'b0; upd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  // Lookup, check against the model, then train with the recorded directions.
  task automatic step(input logic [PC_W-1:0] pc, input logic t, input string tag);
    logic g, l, f;
    @(negedge clk);
    lk_en = 1'b1; lk_pc = pc;
    model_predict(pc, g, l, f);
    @(negedge clk);
    lk_en = 1'b0;
    chk(pred_valid, 1'b1, "R2", "valid after lookup");
    chk(pred_taken, f, tag, "final");
    chk(pred_glob,  g, tag, "global");
    chk(pred_loc,   l, tag, "local");
    upd_en = 1'b1; upd_pc = pc; upd_taken = t;
    upd_glob_pred = g; upd_loc_pred = l;
    @(negedge clk);
    upd_en = 1'b0;
    chk(pred_valid, 1'b0, "R2", "valid low when idle");
    model_update(pc, t, g, l);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic g, l, f;
    do_reset();

    // R1: reset state seen at the ports.
    @(negedge clk);
    chk(pred_valid, 1'b0, "R2", "valid after reset");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); lk_en = 1'b1; lk_pc = PC_W'(k * 37 + 5);
      @(negedge clk); lk_en = 1'b0;
      chk(pred_taken, 1'b0, "R1", "reset final");
      chk(pred_glob,  1'b0, "R1", "reset global");
      chk(pred_loc,   1'b0, "R1", "reset local");
    end

    // Vector walk: mixed addresses and outcomes.
    for (int k = 0; k < 24; k++)
      step(VEC[k][15:0], VEC[k][16], "R3 R4 R6");

    // R4 hysteresis and R8 selector, using a loop-closing pattern.
    for (int rep = 0; rep < 6; rep++)
      for (int it = 0; it < 8; it++)
        step(16'h0042, (it != 7), "R8 R5 R7 R4");

    // R6 saturation: one address driven the same way many times.
    for (int k = 0; k < 12; k++) step(16'h0001, 1'b0, "R6");
    for (int k = 0; k < 12; k++) step(16'h0001, 1'b1, "R6 R4");

    // R9: aliased addresses share local history and selector.
    do_reset();
    for (int k = 0; k < 4; k++) step(16'h0015, 1'b1, "R9");
    step(16'h0A15, 1'b1, "R9");
    step(16'h0A15, 1'b0, "R9");

    // R1: a second reset clears all trained state.
    do_reset();
    @(negedge clk); lk_en = 1'b1; lk_pc = 16'h0015;
    @(negedge clk); lk_en = 1'b0;
    chk(pred_taken, 1'b0, "R1", "re-reset final");
    chk(pred_loc,   1'b0, "R1", "re-reset local");

    // R10: lookup and update at one address on the same edge.
    for (int k = 0; k < 5; k++) step(16'h0033, 1'b1, "R10");
    @(negedge clk);
    model_predict(16'h0033, g, l, f);
    lk_en = 1'b1; lk_pc = 16'h0033;
    upd_en = 1'b1; upd_pc = 16'h0033; upd_taken = 1'b0;
    upd_glob_pred = g; upd_loc_pred = l;
    @(negedge clk);
    lk_en = 1'b0; upd_en = 1'b0;
    chk(pred_taken, f, "R10", "same-edge final");
    chk(pred_glob,  g, "R10", "same-edge global");
    chk(pred_loc,   l, "R10", "same-edge local");
    model_update(16'h0033, 1'b0, g, l);
    step(16'h0033, 1'b0, "R10");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule